// File: doc/BRIEF.md
# Regime-Scoped TLB Flush Engine

This block keeps the valid bits and scope tags of a small fully associative TLB and carries out one operation on them: invalidate every entry that belongs to the guest-kernel (EL1&0) translation regime of one chosen security state. It clears only the local array. Other cores are not told about the flush. The tag compare looks only at the regime, at the security state and, in one variant, at the XS attribute. Virtual machine identifiers, address space identifiers, the global flag, the translation stage and the walk level play no part in it, so the array does not store them. The translation payload lives in a neighbouring structure.

A command has two fields: a two-bit security selector and a flag that picks the XS-excluding variant. Once a command is taken, the engine visits one entry per clock. While it runs it holds off writes from the fill port. After the sweep it waits until the memory accesses that were in flight when the command arrived have retired, and then it raises a one-cycle done pulse. Two counters track in-flight accesses, one for accesses whose XS attribute is 0 and one for accesses whose XS attribute is 1. The plain command waits for both classes. The XS-excluding variant waits only for the XS=0 class.

Top module: `tlb_regime_flush`

## Requirements
- R1: While reset is held, and in the first cycle after it, `entry_valid` is all zero and both `fill_stall` and `flush_done` are 0.
- R2: When `fill_stall` is 0, a `fill_valid` cycle marks entry `fill_idx` valid from the next cycle and stores its regime flag, security tag and XS flag.
- R3: A command is taken only when the engine is idle. `fill_stall` is 1 from the cycle after it is taken until `flush_done` rises. A `cmd_valid` that arrives while `fill_stall` is 1 is ignored.
- R4: A command clears exactly the valid entries whose regime flag is 1 and whose two-bit security tag equals the selector. Entries with a regime flag of 0, or with a different security tag, stay valid.
- R5: The selector and tag encoding is 00 Secure, 01 Non-secure and 11 Realm. The selector 10 clears no entry.
- R6: A plain command (`cmd_nxs`=0) clears matching entries whatever their XS flag. With `cmd_nxs`=1 and the default `NXS_CLEARS_XS`=0, matching entries whose XS flag is 1 stay valid.
- R7: The sweep clears at most one entry per cycle and clears none outside a sweep. When no qualifying access is outstanding, `flush_done` rises ENTRIES+1 cycles after the clock edge that takes the command.
- R8: A plain command does not raise `flush_done` until every access of either XS class that was outstanding when the command was taken has retired. `flush_done` rises two edges after the retire cycle of the last such access.
- R9: A command with `cmd_nxs`=1 waits only for the XS=0 accesses that were outstanding when it was taken. Outstanding XS=1 accesses do not hold it back.
- R10: Accesses issued after the command was taken do not delay `flush_done`.
- R11: While `fill_stall` is 1, a fill request writes nothing and no invalid entry becomes valid.
- R12: `flush_done` is a single-cycle pulse, one per command taken, and it is only high while `fill_stall` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Flush command request |
| cmd_sec | input | 2 | Security selector (00 S, 01 NS, 11 Realm, 10 reserved) |
| cmd_nxs | input | 1 | 1 = XS-excluding variant |
| fill_valid | input | 1 | Write an entry |
| fill_idx | input | IDX_W | Entry index to write |
| fill_el10 | input | 1 | Entry belongs to the EL1&0 regime |
| fill_sec | input | 2 | Entry security tag, same encoding as cmd_sec |
| fill_xs | input | 1 | Entry XS attribute |
| fill_stall | output | 1 | Engine busy; fills and commands are not taken |
| acc_issue | input | 1 | A memory access was issued |
| acc_issue_xs | input | 1 | XS attribute of the issued access |
| acc_retire | input | 1 | A memory access retired |
| acc_retire_xs | input | 1 | XS attribute of the retired access |
| entry_valid | output | ENTRIES | Valid bit of each entry |
| flush_done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is an engine that has finished its sweep but is still held in the drain wait, for a while, by accesses of one XS class while accesses of the other class are also outstanding. The bench issues accesses of both classes before it sends a command and then waits well past the sweep length. It checks that no done pulse has appeared and that fills are still stalled. It then retires the accesses class by class and expects done exactly two edges after the last qualifying retire. The same setup, run with the XS-excluding variant, must complete on the sweep schedule even though XS=1 accesses remain in flight. A fill request and a second command are driven into the middle of a sweep to show that both are ignored.

// File: rtl/tlbf_pkg.sv
// Package: shared types of the regime-scoped TLB flush engine.
// Assumes: the security code is two bits, and one tag encoding is used for
// both entries and commands.
package tlbf_pkg;

    localparam logic [1:0] SEC_SECURE = 2'b00;
    localparam logic [1:0] SEC_NONSEC = 2'b01;
    localparam logic [1:0] SEC_RSVD   = 2'b10;
    localparam logic [1:0] SEC_REALM  = 2'b11;

    // Scope tag held per entry; only what the flush compare needs.
    typedef struct packed {
        logic       el10;
        logic [1:0] sec;
        logic       xs;
    } ent_attr_t;

    typedef enum logic [1:0] {
        FL_IDLE  = 2'b00,
        FL_SWEEP = 2'b01,
        FL_DRAIN = 2'b10
    } flush_st_e;

endpackage

// File: rtl/tlbf_entry_array.sv
// Module: valid bits and scope tags of the TLB entries.
// One write port (fill) and one clear port (sweep); one tag read port.
// Assumes: the caller never asserts write and clear for the same entry
// in the same cycle (the top blocks fills while sweeping).
module tlbf_entry_array
    import tlbf_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  ent_attr_t          wr_attr,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    input  logic [IDX_W-1:0]   rd_idx,
    output ent_attr_t          rd_attr,
    output logic [ENTRIES-1:0] valid
);

    ent_attr_t attr_q [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        // Valid bit: set by a fill, dropped by a sweep clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid[i] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                valid[i] <= 1'b1;
            end else if (clr_en && (clr_idx == IDX_W'(i))) begin
                valid[i] <= 1'b0;
            end
        end

        // Scope tag: captured on a fill.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                attr_q[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                attr_q[i] <= wr_attr;
            end
        end
    end

    // Tag read for the entry the sweep is visiting.
    assign rd_attr = attr_q[rd_idx];

endmodule

// File: rtl/tlbf_scope_match.sv
// Module: decides whether one entry falls inside the flush scope.
// Assumes: with REALM_EN=0 only the low (NS) selector bit is meaningful.
module tlbf_scope_match
    import tlbf_pkg::*;
#(
    parameter bit REALM_EN      = 1'b1,
    parameter bit NXS_CLEARS_XS = 1'b0
) (
    input  logic      ent_valid,
    input  ent_attr_t attr,
    input  logic [1:0] sel_sec,
    input  logic      sel_nxs,
    output logic      hit
);

    logic [1:0] eff_sec;
    logic       sel_rsvd;
    logic       keep_xs;

    if (REALM_EN) begin : g_three_state
        assign eff_sec  = sel_sec;
        assign sel_rsvd = (sel_sec == SEC_RSVD);
    end else begin : g_two_state
        assign eff_sec  = {1'b0, sel_sec[0]};
        assign sel_rsvd = 1'b0;
    end

    // The XS-excluding variant spares XS entries unless built to clear them.
    assign keep_xs = sel_nxs && attr.xs && !NXS_CLEARS_XS;

    // Scope test: regime, security state and XS policy only.
    assign hit = ent_valid && attr.el10 && !sel_rsvd &&
                 (attr.sec == eff_sec) && !keep_xs;

endmodule

// File: rtl/tlbf_drain_track.sv
// Module: in-flight access counters per XS class, with snapshots taken
// when a command starts.
// Assumes: accesses of one class retire in issue order, so each retire
// while a snapshot is nonzero retires one of the snapshotted accesses.
// At most one issue and one retire per cycle.
module tlbf_drain_track #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue_vld,
    input  logic issue_xs,
    input  logic retire_vld,
    input  logic retire_xs,
    input  logic capture,
    input  logic need_xs1,
    output logic drained
);

    logic [1:0] inc;
    logic [1:0] dec;
    logic [1:0] snap_zero;

    assign inc = {issue_vld & issue_xs, issue_vld & ~issue_xs};
    assign dec = {retire_vld & retire_xs, retire_vld & ~retire_xs};

    for (genvar c = 0; c < 2; c++) begin : g_cls
        logic [CNT_W-1:0] live_q;
        logic [CNT_W-1:0] snap_q;

        // Live count of accesses of this class still in flight.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live_q <= '0;
            end else if (inc[c] && !dec[c]) begin
                live_q <= live_q + 1'b1;
            end else if (dec[c] && !inc[c]) begin
                live_q <= live_q - 1'b1;
            end
        end

        // Snapshot: loaded at command start, counts down on retires.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                snap_q <= '0;
            end else if (capture) begin
                snap_q <= live_q - CNT_W'(dec[c]);
            end else if (dec[c] && (snap_q != '0)) begin
                snap_q <= snap_q - 1'b1;
            end
        end

        assign snap_zero[c] = (snap_q == '0);
    end

    // Drained when the required snapshots have reached zero.
    assign drained = snap_zero[0] && (snap_zero[1] || !need_xs1);

endmodule

// File: rtl/tlb_regime_flush.sv
// Module: top of the regime-scoped TLB flush engine.
// Takes a command when idle, sweeps one entry per clock clearing the
// in-scope ones, waits for the snapshotted accesses to drain, then pulses
// flush_done. Fills are stalled for the whole operation.
// Assumes: requesters hold fill_valid while fill_stall is high; commands
// that arrive while busy are dropped.
module tlb_regime_flush
    import tlbf_pkg::*;
#(
    parameter int ENTRIES       = 16,
    parameter int CNT_W         = 8,
    parameter bit REALM_EN      = 1'b1,
    parameter bit NXS_CLEARS_XS = 1'b0,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_sec,
    input  logic               cmd_nxs,
    input  logic               fill_valid,
    input  logic [IDX_W-1:0]   fill_idx,
    input  logic               fill_el10,
    input  logic [1:0]         fill_sec,
    input  logic               fill_xs,
    output logic               fill_stall,
    input  logic               acc_issue,
    input  logic               acc_issue_xs,
    input  logic               acc_retire,
    input  logic               acc_retire_xs,
    output logic [ENTRIES-1:0] entry_valid
    ,
    output logic               flush_done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    flush_st_e        state_q;
    logic [IDX_W-1:0] sweep_idx_q;
    logic [1:0]       run_sec_q;
    logic             run_nxs_q;
    logic             done_q;

    logic             accept;
    logic             wr_en;
    logic             clr_en;
    logic             hit;
    logic             drained;
    ent_attr_t        wr_attr;
    ent_attr_t        rd_attr;

    assign accept     = cmd_valid && (state_q == FL_IDLE);
    assign fill_stall = (state_q != FL_IDLE);
    assign wr_en      = fill_valid && (state_q == FL_IDLE);
    assign clr_en     = (state_q == FL_SWEEP) && hit;
    assign wr_attr    = '{el10: fill_el10, sec: fill_sec, xs: fill_xs};
    assign flush_done = done_q;

    tlbf_entry_array #(
        .ENTRIES (ENTRIES)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (fill_idx),
        .wr_attr (wr_attr),
        .clr_en  (clr_en),
        .clr_idx (sweep_idx_q),
        .rd_idx  (sweep_idx_q),
        .rd_attr (rd_attr),
        .valid   (entry_valid)
    );

    tlbf_scope_match #(
        .REALM_EN      (REALM_EN),
        .NXS_CLEARS_XS (NXS_CLEARS_XS)
    ) u_match (
        .ent_valid (entry_valid[sweep_idx_q]),
        .attr      (rd_attr),
        .sel_sec   (run_sec_q),
        .sel_nxs   (run_nxs_q),
        .hit       (hit)
    );

    tlbf_drain_track #(
        .CNT_W (CNT_W)
    ) u_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_vld  (acc_issue),
        .issue_xs   (acc_issue_xs),
        .retire_vld (acc_retire),
        .retire_xs  (acc_retire_xs),
        .capture    (accept),
        .need_xs1   (!run_nxs_q),
        .drained    (drained)
    );

    // Sequencer: idle -> sweep every entry -> wait for drain -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= FL_IDLE;
            sweep_idx_q <= '0;
        end else begin
            case (state_q)
                FL_IDLE: begin
                    if (accept) begin
                        state_q     <= FL_SWEEP;
                        sweep_idx_q <= '0;
                    end
                end
                FL_SWEEP: begin
                    if (sweep_idx_q == LAST_IDX) begin
                        state_q <= FL_DRAIN;
                    end else begin
                        sweep_idx_q <= sweep_idx_q + 1'b1;
                    end
                end
                FL_DRAIN: begin
                    if (drained) begin
                        state_q <= FL_IDLE;
                    end
                end
                default: state_q <= FL_IDLE;
            endcase
        end
    end

    // Command latch: selector and variant held for the whole operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_sec_q <= SEC_RSVD;
            run_nxs_q <= 1'b0;
        end else if (accept) begin
            run_sec_q <= cmd_sec;
            run_nxs_q <= cmd_nxs;
        end
    end

    // Completion pulse: one cycle, as the engine returns to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == FL_DRAIN) && drained;
        end
    end

endmodule

// File: rtl/tlbf_flush_checker.sv
// Checker: temporal properties of the flush engine, bound to its top.
module tlbf_flush_checker #(
    parameter int ENTRIES = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic               fill_stall,
    input logic [ENTRIES-1:0] entry_valid,
    input logic               flush_done,
    input logic [1:0]         run_sec
);

    assert_accept_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !fill_stall) |=> fill_stall);

    assert_done_while_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |-> !fill_stall);

    assert_done_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |=> !flush_done);

    assert_no_fill_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fill_stall |=> ((entry_valid & ~$past(entry_valid)) == '0));

    assert_one_clear_per_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_stall |=> ($countones($past(entry_valid) & ~entry_valid) <= 1));

    assert_no_clear_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_stall |=> (($past(entry_valid) & ~entry_valid) == '0));

    assert_reserved_clears_nothing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_stall && (run_sec == 2'b10)) |=> $stable(entry_valid));

endmodule

bind tlb_regime_flush tlbf_flush_checker #(
    .ENTRIES (ENTRIES)
) u_flush_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .fill_stall  (fill_stall),
    .entry_valid (entry_valid),
    .flush_done  (flush_done),
    .run_sec     (run_sec_q)
);

// File: tb/tlb_regime_flush_test.sv
`timescale 1ns/1ps
// Bench: scoreboard of expected valid masks and done cycles per command.
module tlb_regime_flush_test;

    localparam int N  = 16;
    localparam int IW = 4;

    typedef struct {
        logic [N-1:0] mask;
        int           at;
        string        req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cmd_valid;
    logic [1:0]    cmd_sec;
    logic          cmd_nxs;
    logic          fill_valid;
    logic [IW-1:0] fill_idx;
    logic          fill_el10;
    logic [1:0]    fill_sec;
    logic          fill_xs;
    logic          fill_stall;
    logic          acc_issue;
    logic          acc_issue_xs;
    logic          acc_retire;
    logic          acc_retire_xs;
    logic [N-1:0]  entry_valid;
    logic          flush_done;

    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    int   done_seen = 0;
    exp_t sb[$];

    bit       m_v    [N];
    bit       m_el10 [N];
    bit [1:0] m_sec  [N];
    bit       m_xs   [N];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    tlb_regime_flush #(.ENTRIES(N)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_sec       (cmd_sec),
        .cmd_nxs       (cmd_nxs),
        .fill_valid    (fill_valid),
        .fill_idx      (fill_idx),
        .fill_el10     (fill_el10),
        .fill_sec      (fill_sec),
        .fill_xs       (fill_xs),
        .fill_stall    (fill_stall),
        .acc_issue     (acc_issue),
        .acc_issue_xs  (acc_issue_xs),
        .acc_retire    (acc_retire),
        .acc_retire_xs (acc_retire_xs),
        .entry_valid   (entry_valid),
        .flush_done    (flush_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops one expectation per done pulse and compares it.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n === 1'b1 && flush_done === 1'b1) begin
            done_seen++;
            if (sb.size() == 0) begin
                chk(1'b0, "R12", "unexpected done pulse", 1, 0);
            end else begin
                e = sb.pop_front();
                chk(entry_valid == e.mask, e.req, "valid mask at done",
                    longint'(entry_valid), longint'(e.mask));
                if (e.at != 0)
                    chk(cyc == e.at, e.req, "done cycle", cyc, e.at);
            end
        end
    end

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R12", "watchdog expired", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_fill(input int i, input bit el, input bit [1:0] s, input bit x);
        fill_valid = 1'b1;
        fill_idx   = IW'(i);
        fill_el10  = el;
        fill_sec   = s;
        fill_xs    = x;
        @(negedge clk);
        fill_valid = 1'b0;
        m_v[i] = 1'b1; m_el10[i] = el; m_sec[i] = s; m_xs[i] = x;
    endtask

    task automatic fill_all(input int seed);
        for (int i = 0; i < N; i++) begin
            bit [1:0] s;
            case ((i + seed) % 3)
                0:       s = 2'b00;
                1:       s = 2'b01;
                default: s = 2'b11;
            endcase
            do_fill(i, (i % 5) != 4, s, (i % 4) == 1);
        end
    endtask

    // Expected result of a flush, from the requirements (R4, R5, R6).
    task automatic model_flush(input bit [1:0] s, input bit nxs, output logic [N-1:0] m);
        for (int i = 0; i < N; i++) begin
            if (m_v[i] && m_el10[i] && s != 2'b10 && m_sec[i] == s && !(nxs && m_xs[i]))
                m_v[i] = 1'b0;
            m[i] = m_v[i];
        end
    endtask

    task automatic start_flush(input bit [1:0] s, input bit nxs,
                               output logic [N-1:0] m, output int c);
        model_flush(s, nxs, m);
        c = cyc;
        cmd_valid = 1'b1;
        cmd_sec   = s;
        cmd_nxs   = nxs;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(input int prev);
        int guard = 0;
        while (done_seen == prev && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
    endtask

    // Plain scheduled flush: nothing outstanding, done on the sweep schedule.
    task automatic sched_flush(input bit [1:0] s, input bit nxs, input string req);
        logic [N-1:0] m;
        int c;
        int prev = done_seen;
        start_flush(s, nxs, m, c);
        sb.push_back('{mask: m, at: c + N + 2, req: req});
        wait_done(prev);
        chk(flush_done == 1'b0, "R12", "done after pulse", flush_done, 0);
    endtask

    task automatic issue(input bit x);
        acc_issue = 1'b1; acc_issue_xs = x;
        @(negedge clk);
        acc_issue = 1'b0;
    endtask

    task automatic retire(input bit x);
        acc_retire = 1'b1; acc_retire_xs = x;
        @(negedge clk);
        acc_retire = 1'b0;
    endtask

    initial begin
        logic [N-1:0] m;
        int c;
        int prev;
        int hole;
        rst_n = 1'b0; cmd_valid = 0; cmd_sec = 0; cmd_nxs = 0;
        fill_valid = 0; fill_idx = 0; fill_el10 = 0; fill_sec = 0; fill_xs = 0;
        acc_issue = 0; acc_issue_xs = 0; acc_retire = 0; acc_retire_xs = 0;
        for (int i = 0; i < N; i++) begin m_v[i] = 0; m_el10[i] = 0; m_sec[i] = 0; m_xs[i] = 0; end
        tick(3);
        chk(entry_valid == '0, "R1", "valid in reset", longint'(entry_valid), 0);
        rst_n = 1'b1;
        tick(1);
        chk(entry_valid == '0, "R1", "valid after reset", longint'(entry_valid), 0);
        chk(fill_stall == 1'b0, "R1", "stall after reset", fill_stall, 0);
        chk(flush_done == 1'b0, "R1", "done after reset", flush_done, 0);

        // R2: fills mark every entry valid.
        fill_all(0);
        chk(entry_valid == '1, "R2", "valid after fills", longint'(entry_valid), longint'({N{1'b1}}));

        // R4/R6/R7: plain Non-secure flush clears in-scope entries incl. XS.
        sched_flush(2'b01, 1'b0, "R4");
        // R5: Secure and Realm selectors on fresh contents.
        fill_all(1);
        sched_flush(2'b00, 1'b0, "R5");
        fill_all(2);
        sched_flush(2'b11, 1'b0, "R5");
        // R5: reserved selector clears nothing.
        sched_flush(2'b10, 1'b0, "R5");

        // R6: XS-excluding variant spares XS entries; plain then clears them.
        fill_all(0);
        sched_flush(2'b01, 1'b1, "R6");
        sched_flush(2'b01, 1'b0, "R6");

        // R11/R3: fill and second command during a sweep are ignored.
        hole = 0;
        for (int i = N - 1; i >= 0; i--) if (!m_v[i]) hole = i;
        prev = done_seen;
        start_flush(2'b00, 1'b0, m, c);
        sb.push_back('{mask: m, at: c + N + 2, req: "R3"});
        cmd_valid = 1'b1; cmd_sec = 2'b11; cmd_nxs = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        fill_valid = 1'b1; fill_idx = IW'(hole); fill_el10 = 1; fill_sec = 2'b01; fill_xs = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(fill_stall == 1'b1, "R11", "stall during sweep", fill_stall, 1);
            chk(entry_valid[hole] == 1'b0, "R11", "stalled fill wrote", entry_valid[hole], 0);
        end
        fill_valid = 1'b0;
        wait_done(prev);
        chk(entry_valid[hole] == 1'b0, "R11", "entry after stalled fill", entry_valid[hole], 0);

        // R8: plain command waits for both classes.
        fill_all(2);
        issue(1'b0); issue(1'b0); issue(1'b1);
        prev = done_seen;
        start_flush(2'b01, 1'b0, m, c);
        tick(N + 6);
        chk(done_seen == prev, "R8", "done before drain", done_seen - prev, 0);
        chk(fill_stall == 1'b1, "R8", "stall while draining", fill_stall, 1);
        retire(1'b0); retire(1'b0);
        tick(3);
        chk(done_seen == prev, "R8", "done with XS=1 outstanding", done_seen - prev, 0);
        sb.push_back('{mask: m, at: cyc + 2, req: "R8"});
        retire(1'b1);
        wait_done(prev);

        // R9: XS-excluding command waits for XS=0 only.
        issue(1'b1); issue(1'b1); issue(1'b0);
        prev = done_seen;
        start_flush(2'b00, 1'b1, m, c);
        tick(N + 6);
        chk(done_seen == prev, "R9", "done before XS=0 drain", done_seen - prev, 0);
        sb.push_back('{mask: m, at: cyc + 2, req: "R9"});
        retire(1'b0);
        wait_done(prev);
        sched_flush(2'b11, 1'b1, "R9");
        retire(1'b1); retire(1'b1);

        // R10: accesses issued after the start do not delay completion.
        fill_all(1);
        prev = done_seen;
        start_flush(2'b11, 1'b0, m, c);
        sb.push_back('{mask: m, at: c + N + 2, req: "R10"});
        issue(1'b0); issue(1'b1);
        wait_done(prev);
        retire(1'b0); retire(1'b1);

        tick(5);
        chk(sb.size() == 0, "R12", "pending expectations", sb.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule